// File: doc/BRIEF.md
# Three-Layer Window Compositor

This block sits behind a raster timing generator in a display pipeline. Each cycle it receives the current raster coordinate, a display-enable flag and one pixel from each of three layers. It decides which layers cover that coordinate. Each layer is tested against its own rectangular window. The block then produces one output pixel. Layers two and three are stacked opaquely. Layer one is alpha-blended over the result. Its alpha comes either from the pixel itself or from a programmable global value.

Configuration is held in a small write-only register set reached through a simple write strobe, byte address and 32-bit data. The registers hold three layer enables, an alpha-source select, a global alpha, two corner registers per layer and one background colour per layer. Window corners are absolute frame coordinates. Software normally forms them as the active-area origin plus the layer position, and the bottom corner as the top corner plus the layer size. Pixels carry three 10-bit components and alpha is 8 bits.

Top module: `layer_compositor`

## Requirements
- R1: After reset all layers are disabled, the alpha select is clear, the global alpha is 255, and every corner and background register is zero. While reset is held, `de_o` and `px_o` are zero.
- R2: Writes take effect on the clock edge where `cfg_we` is high, for pixels presented after that edge. The address is compared in full. The control word is at 0x00: bit 2 enables layer one, bit 1 enables layer two, bit 0 enables layer three, bit 10 is the alpha select, and bits 31:24 hold the global alpha. For layer k (k=0 is layer one), the top corner is at 0x10+8k and the bottom corner at 0x14+8k, with x in bits 12:0 and y in bits 28:16. The background colour of layer k is at 0x30+4k, with its three components in bits 29:20, 19:10 and 9:0.
- R3: An enabled layer covers pixel (x,y) when top.x <= x < bottom.x and top.y <= y < bottom.y. A disabled layer covers nothing.
- R4: A layer whose top and bottom corner registers are both entirely zero covers no pixel, even when enabled.
- R5: Where layer two covers, its pixel forms the under colour and hides layer three. Where only layer three covers, its pixel forms the under colour.
- R6: Where neither layer two nor layer three covers, the under colour is the background register of the highest-priority enabled layer. Priority runs layer one, then two, then three. With no layer enabled, layer three's background is used.
- R7: Where layer one covers, each output component is (a*F + (255-a)*U + 127)/255, using integer division, with F the layer-one component and U the under component. Elsewhere the output is the under colour.
- R8: With the alpha select set, a is the per-pixel `l1_alpha`. With it clear, a is the global alpha.
- R9: The output has one cycle of latency. `de_o` equals `de_i` of the previous cycle, and `px_o` is zero whenever `de_o` is low.
- R10: A write to any address outside the map in R2 changes no configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 32 | Configuration write data |
| ras_x | input | 13 | Raster column of the current pixel |
| ras_y | input | 13 | Raster row of the current pixel |
| de_i | input | 1 | Display enable for the current pixel |
| l1_px | input | 30 | Layer-one pixel, three 10-bit components |
| l1_alpha | input | 8 | Layer-one per-pixel alpha |
| l2_px | input | 30 | Layer-two pixel |
| l3_px | input | 30 | Layer-three pixel |
| px_o | output | 30 | Composited pixel, registered |
| de_o | output | 1 | Display enable aligned with `px_o` |

## Verification
The assertions assume the following about the inputs. `de_i` stays low while reset is held. All inputs change only away from the rising edge, so the value captured one cycle earlier is the one a property compares against. The stimulus drives every input on the falling edge. It holds display-enable low through reset and during every configuration write. It then sweeps every coordinate of a 20x12 frame for each configuration. That configuration set covers window edges, the zero-window rule, overlapping layers, the background fallbacks, global alpha values of 0, 128 and 255, and per-pixel alpha.

// File: rtl/lcomp_pkg.sv
package lcomp_pkg;
  localparam int XY_W       = 13;
  localparam int CMP_W      = 10;
  localparam int N_CMP      = 3;
  localparam int PIX_W      = N_CMP * CMP_W;
  localparam int A_W        = 8;
  localparam int N_LYR      = 3;
  localparam int ADDR_W     = 8;
  localparam int DATA_W     = 32;
  localparam int X_LSB      = 0;
  localparam int Y_LSB      = 16;
  localparam int SEL_BIT    = 10;
  localparam int GA_LSB     = 24;
  localparam int WIN_STRIDE = 8;
  localparam int BOT_OFS    = 4;
  localparam int BG_STRIDE  = 4;
  localparam logic [ADDR_W-1:0] A_CTRL = 8'h00;
  localparam logic [ADDR_W-1:0] A_WIN0 = 8'h10;
  localparam logic [ADDR_W-1:0] A_BG0  = 8'h30;

  typedef logic [XY_W-1:0]  coord_t;
  typedef logic [PIX_W-1:0] pix_t;
  typedef logic [A_W-1:0]   alpha_t;

  typedef struct packed {
    coord_t x0;
    coord_t y0;
    coord_t x1;
    coord_t y1;
  } win_t;
endpackage

// File: rtl/lcomp_regs.sv
module lcomp_regs
  import lcomp_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       wdata,
  output logic [N_LYR-1:0]        en_o,
  output logic                    sel_o,
  output alpha_t                  ga_o,
  output win_t [N_LYR-1:0]        win_o,
  output pix_t [N_LYR-1:0]        bg_o
);
  // Control word fields; en bit k belongs to layer k (k=0 is layer one)
  logic               ctrl_we;
  logic [N_LYR-1:0]   en_q, en_d;
  logic               sel_q, sel_d;
  alpha_t             ga_q, ga_d;
  logic               unused_wdata_bits;

  assign unused_wdata_bits = ^wdata;

  always_comb begin
    ctrl_we = we && (addr == A_CTRL);
    for (int k = 0; k < N_LYR; k++) begin
      en_d[k] = wdata[N_LYR-1-k];
    end
    sel_d = wdata[SEL_BIT];
    ga_d  = wdata[GA_LSB +: A_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      sel_q <= 1'b0;
      ga_q  <= '1;
    end else if (ctrl_we) begin
      en_q  <= en_d;
      sel_q <= sel_d;
      ga_q  <= ga_d;
    end
  end

  assign en_o  = en_q;
  assign sel_o = sel_q;
  assign ga_o  = ga_q;

  for (genvar k = 0; k < N_LYR; k++) begin : g_lyr
    localparam logic [ADDR_W-1:0] A_TOP = A_WIN0 + ADDR_W'(WIN_STRIDE * k);
    localparam logic [ADDR_W-1:0] A_BOT = A_TOP + ADDR_W'(BOT_OFS);
    localparam logic [ADDR_W-1:0] A_BG  = A_BG0 + ADDR_W'(BG_STRIDE * k);

    logic top_we, bot_we, bg_we;
    win_t win_q, win_d;
    pix_t bg_q, bg_d;

    always_comb begin
      top_we = we && (addr == A_TOP);
      bot_we = we && (addr == A_BOT);
      bg_we  = we && (addr == A_BG);
      win_d  = win_q;
      if (top_we) begin
        win_d.x0 = wdata[X_LSB +: XY_W];
        win_d.y0 = wdata[Y_LSB +: XY_W];
      end
      if (bot_we) begin
        win_d.x1 = wdata[X_LSB +: XY_W];
        win_d.y1 = wdata[Y_LSB +: XY_W];
      end
      bg_d = wdata[PIX_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        win_q <= '0;
      end else if (top_we || bot_we) begin
        win_q <= win_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bg_q <= '0;
      end else if (bg_we) begin
        bg_q <= bg_d;
      end
    end

    assign win_o[k] = win_q;
    assign bg_o[k]  = bg_q;
  end
endmodule

// File: rtl/lcomp_win.sv
module lcomp_win
  import lcomp_pkg::*;
(
  input  coord_t x,
  input  coord_t y,
  input  logic   en,
  input  win_t   win,
  output logic   cov
);
  logic live, in_x, in_y;

  always_comb begin
    live = en && (win != '0);
    in_x = (x >= win.x0) && (x < win.x1);
    in_y = (y >= win.y0) && (y < win.y1);
    cov  = live && in_x && in_y;
  end
endmodule

// File: rtl/lcomp_blend.sv
module lcomp_blend
  import lcomp_pkg::*;
(
  input  pix_t   fg,
  input  pix_t   bg,
  input  alpha_t a,
  output pix_t   mix
);
  localparam int NUM_W = CMP_W + A_W + 1;
  localparam logic [NUM_W-1:0] A_FULL = NUM_W'((1 << A_W) - 1);
  localparam logic [NUM_W-1:0] RND    = NUM_W'(((1 << A_W) - 1) / 2);

  alpha_t a_inv;
  assign a_inv = ~a;

  for (genvar c = 0; c < N_CMP; c++) begin : g_cmp
    logic [NUM_W-1:0] num;
    assign num = NUM_W'(a) * NUM_W'(fg[c*CMP_W +: CMP_W])
               + NUM_W'(a_inv) * NUM_W'(bg[c*CMP_W +: CMP_W])
               + RND;
    assign mix[c*CMP_W +: CMP_W] = CMP_W'(num / A_FULL);
  end
endmodule

// File: rtl/layer_compositor.sv
module layer_compositor
  import lcomp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [XY_W-1:0]   ras_x,
  input  logic [XY_W-1:0]   ras_y,
  input  logic              de_i,
  input  logic [PIX_W-1:0]  l1_px,
  input  logic [A_W-1:0]    l1_alpha,
  input  logic [PIX_W-1:0]  l2_px,
  input  logic [PIX_W-1:0]  l3_px,
  output logic [PIX_W-1:0]  px_o,
  output logic              de_o
);
  logic [N_LYR-1:0] en;
  logic             sel;
  alpha_t           ga;
  win_t [N_LYR-1:0] win;
  pix_t [N_LYR-1:0] bg;
  logic [N_LYR-1:0] cov;
  pix_t [N_LYR-1:0] lpx;
  pix_t             fill_c, under_c, mix_c, px_d;
  alpha_t           a_c;
  pix_t             px_q;
  logic             de_q;

  assign lpx = {l3_px, l2_px, l1_px};

  lcomp_regs u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .en_o  (en),
    .sel_o (sel),
    .ga_o  (ga),
    .win_o (win),
    .bg_o  (bg)
  );

  for (genvar k = 0; k < N_LYR; k++) begin : g_win
    lcomp_win u_win (
      .x   (ras_x),
      .y   (ras_y),
      .en  (en[k]),
      .win (win[k]),
      .cov (cov[k])
    );
  end

  // Fallback colour: background of the highest-priority enabled layer
  always_comb begin
    fill_c = bg[N_LYR-1];
    for (int k = N_LYR - 1; k >= 0; k--) begin
      if (en[k]) fill_c = bg[k];
    end
  end

  // Opaque stack of layers two and three; lower index wins
  always_comb begin
    under_c = fill_c;
    for (int k = N_LYR - 1; k >= 1; k--) begin
      if (cov[k]) under_c = lpx[k];
    end
  end

  assign a_c = (sel && cov[0]) ? l1_alpha : ga;

  lcomp_blend u_blend (
    .fg  (l1_px),
    .bg  (under_c),
    .a   (a_c),
    .mix (mix_c)
  );

  always_comb begin
    if (!de_i)       px_d = '0;
    else if (cov[0]) px_d = mix_c;
    else             px_d = under_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      px_q <= '0;
      de_q <= 1'b0;
    end else begin
      px_q <= px_d;
      de_q <= de_i;
    end
  end

  assign px_o = px_q;
  assign de_o = de_q;
endmodule

// File: rtl/lcomp_chk.sv
module lcomp_chk
  import lcomp_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             de_i,
  input logic             de_o,
  input logic [PIX_W-1:0] px_o,
  input logic [N_LYR-1:0] cov,
  input logic [A_W-1:0]   a_c,
  input logic [PIX_W-1:0] l1_px,
  input logic [PIX_W-1:0] l2_px,
  input logic [PIX_W-1:0] fill_c
);
  p_de_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    de_i |=> de_o);

  p_de_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !de_i |=> !de_o);

  p_blank_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !de_o |-> (px_o == '0));

  p_opaque_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (de_i && cov[0] && (a_c == '1)) |=> (px_o == $past(l1_px)));

  p_l2_hides_l3_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (de_i && !cov[0] && cov[1]) |=> (px_o == $past(l2_px)));

  p_fill_bg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (de_i && (cov == '0)) |=> (px_o == $past(fill_c)));
endmodule

bind layer_compositor lcomp_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .de_i   (de_i),
  .de_o   (de_o),
  .px_o   (px_o),
  .cov    (cov),
  .a_c    (a_c),
  .l1_px  (l1_px),
  .l2_px  (l2_px),
  .fill_c (fill_c)
);

// File: tb/layer_compositor_tb_top.sv
module layer_compositor_tb_top;
  localparam int CLK_P  = 10;
  localparam int FW     = 20;
  localparam int FH     = 12;
  localparam int WD_CYC = 100000;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [7:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [12:0] ras_x;
  logic [12:0] ras_y;
  logic        de_i;
  logic [29:0] l1_px;
  logic [7:0]  l1_alpha;
  logic [29:0] l2_px;
  logic [29:0] l3_px;
  logic [29:0] px_o;
  logic        de_o;

  int checks = 0;
  int errors = 0;

  // Bench-side configuration model
  bit          m_en [3];
  bit          m_sel;
  int          m_ga;
  int          m_x0 [3];
  int          m_y0 [3];
  int          m_x1 [3];
  int          m_y1 [3];
  logic [29:0] m_bg [3];

  layer_compositor dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .ras_x     (ras_x),
    .ras_y     (ras_y),
    .de_i      (de_i),
    .l1_px     (l1_px),
    .l1_alpha  (l1_alpha),
    .l2_px     (l2_px),
    .l3_px     (l3_px),
    .px_o      (px_o),
    .de_o      (de_o)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [29:0] pgen(int k, int x, int y);
    return {10'(x*37 + y*11 + k*200), 10'(y*53 + x*7 + k*91 + 5),
            10'(x*y*13 + k*333 + 1)};
  endfunction

  function automatic logic [7:0] agen(int x, int y);
    return 8'(x*29 + y*71 + 3);
  endfunction

  function automatic logic [29:0] model(int x, int y);
    logic [29:0] p [3];
    bit          c [3];
    logic [29:0] fill;
    logic [29:0] under;
    logic [29:0] res;
    int          a;
    for (int k = 0; k < 3; k++) begin
      p[k] = pgen(k, x, y);
      c[k] = m_en[k]
          && !(m_x0[k] == 0 && m_y0[k] == 0 && m_x1[k] == 0 && m_y1[k] == 0)
          && x >= m_x0[k] && x < m_x1[k] && y >= m_y0[k] && y < m_y1[k];
    end
    fill = m_bg[2];
    if (m_en[1]) fill = m_bg[1];
    if (m_en[0]) fill = m_bg[0];
    under = c[1] ? p[1] : (c[2] ? p[2] : fill);
    if (!c[0]) return under;
    a = m_sel ? int'(agen(x, y)) : m_ga;
    for (int i = 0; i < 3; i++) begin
      int f;
      int b;
      int r;
      f = int'(p[0][i*10 +: 10]);
      b = int'(under[i*10 +: 10]);
      r = (a*f + (255 - a)*b + 127) / 255;
      res[i*10 +: 10] = 10'(r);
    end
    return res;
  endfunction

  task automatic wr(input logic [7:0] addr, input logic [31:0] data);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_addr  = addr;
    cfg_wdata = data;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  // R2: control word layout
  task automatic set_ctrl(input bit e1, input bit e2, input bit e3,
                          input bit sel, input int ga);
    m_en[0] = e1; m_en[1] = e2; m_en[2] = e3; m_sel = sel; m_ga = ga;
    wr(8'h00, (32'(ga) << 24) | (32'(sel) << 10) | (32'(e1) << 2) |
              (32'(e2) << 1) | 32'(e3));
  endtask

  task automatic set_win(input int k, input int x0, input int y0,
                         input int x1, input int y1);
    m_x0[k] = x0; m_y0[k] = y0; m_x1[k] = x1; m_y1[k] = y1;
    wr(8'(8'h10 + 8*k), (32'(y0) << 16) | 32'(x0));
    wr(8'(8'h14 + 8*k), (32'(y1) << 16) | 32'(x1));
  endtask

  task automatic set_bg(input int k, input logic [29:0] c);
    m_bg[k] = c;
    wr(8'(8'h30 + 4*k), {2'b00, c});
  endtask

  task automatic run_frame(input string tag);
    logic [29:0] exp_prev;
    bit          have;
    have = 1'b0;
    exp_prev = '0;
    for (int y = 0; y < FH; y++) begin
      for (int x = 0; x < FW; x++) begin
        @(negedge clk);
        if (have) chk(de_o === 1'b1 && px_o === exp_prev, tag,
                      {1'b0, de_o, px_o}, {2'b01, exp_prev});
        ras_x    = 13'(x);
        ras_y    = 13'(y);
        de_i     = 1'b1;
        l1_px    = pgen(0, x, y);
        l2_px    = pgen(1, x, y);
        l3_px    = pgen(2, x, y);
        l1_alpha = agen(x, y);
        exp_prev = model(x, y);
        have     = 1'b1;
      end
    end
    @(negedge clk);
    chk(de_o === 1'b1 && px_o === exp_prev, tag,
        {1'b0, de_o, px_o}, {2'b01, exp_prev});
    de_i = 1'b0;
    @(negedge clk);
    // R9: blanking one cycle after display-enable falls
    chk(de_o === 1'b0 && px_o === '0, "R9", {1'b0, de_o, px_o}, 32'h0);
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    ras_x = '0; ras_y = '0; de_i = 1'b0;
    l1_px = '0; l2_px = '0; l3_px = '0; l1_alpha = '0;
    for (int k = 0; k < 3; k++) begin
      m_en[k] = 1'b0; m_x0[k] = 0; m_y0[k] = 0; m_x1[k] = 0; m_y1[k] = 0;
      m_bg[k] = '0;
    end
    m_sel = 1'b0;
    m_ga  = 255;
    repeat (3) @(negedge clk);
    // R1: outputs held at zero in reset
    chk(de_o === 1'b0 && px_o === '0, "R1", {1'b0, de_o, px_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(de_o === 1'b0 && px_o === '0, "R1", {1'b0, de_o, px_o}, 32'h0);
    // R1: reset configuration gives zero pixels across the frame
    run_frame("R1");

    set_bg(0, {10'd100, 10'd200, 10'd300});
    set_bg(1, {10'd400, 10'd500, 10'd600});
    set_bg(2, {10'd700, 10'd800, 10'd900});

    // R5 R2: layers two and three overlap, layer one has a window but is disabled
    set_win(0, 0, 0, 20, 12);
    set_win(1, 2, 1, 10, 7);
    set_win(2, 6, 4, 16, 10);
    set_ctrl(1'b0, 1'b1, 1'b1, 1'b0, 255);
    run_frame("R5 R2");

    // R4: enabled layer one with an all-zero window covers nothing
    set_win(0, 0, 0, 0, 0);
    set_ctrl(1'b1, 1'b0, 1'b0, 1'b0, 255);
    run_frame("R4");

    // R7: global alpha 128 over the stack
    set_win(0, 4, 2, 14, 9);
    set_ctrl(1'b1, 1'b1, 1'b1, 1'b0, 128);
    run_frame("R7");

    // R8: per-pixel alpha selected
    set_ctrl(1'b1, 1'b1, 1'b1, 1'b1, 128);
    run_frame("R8");

    // R3: window edges, opaque layer one
    set_win(0, 3, 2, 8, 6);
    set_ctrl(1'b1, 1'b1, 1'b1, 1'b0, 255);
    run_frame("R3");

    // R10: writes to unmapped addresses leave the frame unchanged
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h11, 32'hFFFF_FFFF);
    wr(8'h28, 32'hFFFF_FFFF);
    wr(8'h3C, 32'hFFFF_FFFF);
    wr(8'h01, 32'hFFFF_FFFF);
    run_frame("R10");

    // R6: only layer three enabled, its background fills the rest
    set_win(2, 5, 5, 9, 8);
    set_ctrl(1'b0, 1'b0, 1'b1, 1'b0, 255);
    run_frame("R6");

    // R6: layer two enabled with zero window, its background takes priority
    set_win(1, 0, 0, 0, 0);
    set_ctrl(1'b0, 1'b1, 1'b1, 1'b0, 255);
    run_frame("R6");

    // R7: global alpha zero leaves the under colour
    set_win(0, 0, 0, 20, 12);
    set_win(1, 2, 1, 10, 7);
    set_ctrl(1'b1, 1'b1, 1'b1, 1'b0, 0);
    run_frame("R7");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule